// File: doc/BRIEF.md
# Bit-Serial Four-Stage Comb Differencer

This block is the low-rate back end of a fourth-order sinc decimator. Once per output frame, a capture strobe hands it a 24-bit word taken from the integrator chain. The block runs that word through four cascaded differencing stages. Each stage subtracts the word it saw on the previous frame from the word it sees now, and passes the result to the next stage. All arithmetic wraps modulo 2^24.

The word rate is far below the clock rate, so every stage works one bit per clock. Bits go least significant first, through a one-bit subtractor that keeps its borrow in a flip-flop. A 24-bit shift register holds the stage's history, and it moves in step with the serial data: the old word leaves as the new word enters. The fourth stage's result leaves on one serial pin. A frame-sync pin marks its least significant bit.

Top module: `sinc_comb_serial`

## Requirements
- R1: A synchronous reset clears all four history words, and both outputs read 0 after the reset edge. The first word after reset therefore comes out unchanged, because it is four subtractions of zero.
- R2: `cap_stb` high at a rising edge loads `cap_word` at that edge. Bit j of the result is driven on `ser_out` from the (j+1)-th rising edge after the capture edge until the next edge.
- R3: The 24 result bits leave on `ser_out` in the order bit 0 (least significant) to bit 23, one per clock.
- R4: `frm_sync` is 1 only during the cycle that carries bit 0 of a result, and 0 during the other 23 bit cycles.
- R5: Outside the 24 bit cycles of a word, `ser_out` and `frm_sync` are 0.
- R6: Per word: d1 = w - h1, d2 = d1 - h2, d3 = d2 - h3, d4 = d3 - h4. Each stage then stores its own input: h1 = w, h2 = d1, h3 = d2, h4 = d3. The result is d4.
- R7: All differences are two's complement modulo 2^24. A borrow out of bit 23 is discarded.
- R8: Every stage clears its borrow at the start of each word, so a word's result does not depend on the borrow left over from the previous word.
- R9: Strobes spaced exactly 24 clocks apart produce back-to-back results with no idle cycle and correct values.
- R10: `cap_word` is ignored in every cycle where `cap_stb` is low.
- R11: A reset asserted while a word is being shifted out aborts that word and clears the history. The next captured word comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Capture strobe, one pulse per word |
| cap_word | input | 24 | Parallel word from the integrators |
| ser_out | output | 1 | Serial result, least significant bit first |
| frm_sync | output | 1 | High during the cycle that carries bit 0 |

## Verification
The hardest cases to reach from the ports are these:
- a stale borrow leaking into the next word;
- a history register that is only partly shifted when the next word starts.

Random words at a 32-clock spacing leave borrows set at bit 23 in most frames. Extreme words near 0x000000, 0x7FFFFF, 0x800000 and 0xFFFFFF then force wraps through all four stages. A run of strobes exactly 24 clocks apart makes the last bit of one word and the load of the next share a clock edge. A reset dropped in the middle of a word checks that partial history is discarded.

// File: rtl/sinc_comb_pkg.sv
package sinc_comb_pkg;

    parameter int unsigned DEF_WORD_W = 24;
    parameter int unsigned DEF_STAGES = 4;

    typedef struct packed {
        logic diff;
        logic borrow;
    } sub_bit_t;

    // one-bit full subtractor: a - b - bin
    function automatic sub_bit_t bit_sub(input logic a, input logic b, input logic bin);
        sub_bit_t r;
        r.diff   = a ^ b ^ bin;
        r.borrow = (~a & b) | (~(a ^ b) & bin);
        return r;
    endfunction

endpackage

// File: rtl/comb_word_loader.sv
module comb_word_loader
    import sinc_comb_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb,
    input  logic [WORD_W-1:0] cap_word,
    output logic              bit_o,
    output logic              active_o,
    output logic              first_o
);
    localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic              busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (cap_stb) begin
            sh_q   <= cap_word;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end
    end

    assign bit_o    = sh_q[0];
    assign active_o = busy_q;
    assign first_o  = busy_q && (cnt_q == '0);

    AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (active_o && first_o));                                   // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= LAST));                                          // R3
    AST_WORD_END: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == LAST && !cap_stb) |=> !active_o);                // R5

endmodule

// File: rtl/comb_bit_stage.sv
module comb_bit_stage
    import sinc_comb_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic first,
    input  logic din,
    output logic dout
);
    logic [WORD_W-1:0] hist_q;
    logic              brw_q;
    logic              bin;
    sub_bit_t          sb;

    // borrow forced to zero on the first bit of every word
    assign bin  = first ? 1'b0 : brw_q;
    assign sb   = bit_sub(din, hist_q[0], bin);
    assign dout = sb.diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            brw_q  <= 1'b0;
        end else if (en) begin
            hist_q <= {din, hist_q[WORD_W-1:1]};
            brw_q  <= sb.borrow;
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(hist_q));                                             // R10
    AST_HIST_ENTRY: assert property (@(posedge clk) disable iff (rst)
        en |=> (hist_q[WORD_W-1] == $past(din)));                             // R6

endmodule

// File: rtl/comb_serial_framer.sv
module comb_serial_framer (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic first,
    input  logic d,
    output logic ser_o,
    output logic fs_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_o <= 1'b0;
            fs_o  <= 1'b0;
        end else begin
            ser_o <= active ? d : 1'b0;
            fs_o  <= first;
        end
    end

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fs_o |=> !fs_o);                                                      // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!ser_o && !fs_o));                                       // R5

endmodule

// File: rtl/sinc_comb_serial.sv
module sinc_comb_serial
    import sinc_comb_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb,
    input  logic [WORD_W-1:0] cap_word,
    output logic              ser_out,
    output logic              frm_sync
);
    logic              bit_s;
    logic              act_s;
    logic              first_s;
    logic [STAGES:0]   chain;

    comb_word_loader #(.WORD_W(WORD_W)) u_load (
        .clk      (clk),
        .rst      (rst),
        .cap_stb  (cap_stb),
        .cap_word (cap_word),
        .bit_o    (bit_s),
        .active_o (act_s),
        .first_o  (first_s)
    );

    assign chain[0] = bit_s;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        comb_bit_stage #(.WORD_W(WORD_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .en    (act_s),
            .first (first_s),
            .din   (chain[k]),
            .dout  (chain[k+1])
        );
    end

    comb_serial_framer u_frame (
        .clk    (clk),
        .rst    (rst),
        .active (act_s),
        .first  (first_s),
        .d      (chain[STAGES]),
        .ser_o  (ser_out),
        .fs_o   (frm_sync)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ser_out && !frm_sync));                                     // R1

endmodule

// File: tb/sinc_comb_serial_test.sv
module sinc_comb_serial_test;
    localparam int W    = 24;
    localparam int NCYC = 2000;
    localparam int NEXP = NCYC + 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_stb = 1'b0;
    logic [W-1:0] cap_word = '0;
    wire          ser_out;
    wire          frm_sync;

    always #10 clk = ~clk;

    sinc_comb_serial uut (
        .clk      (clk),
        .rst      (rst),
        .cap_stb  (cap_stb),
        .cap_word (cap_word),
        .ser_out  (ser_out),
        .frm_sync (frm_sync)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic         exp_ser [NEXP];
    logic         exp_fs  [NEXP];
    string        exp_tag [NEXP];
    logic [W-1:0] hist    [4];

    function automatic logic [W-1:0] model_word(input logic [W-1:0] x);
        logic [W-1:0] y;
        logic [W-1:0] t;
        y = x;
        for (int k = 0; k < 4; k++) begin
            t       = y;
            y       = y - hist[k];
            hist[k] = t;
        end
        return y;
    endfunction

    function automatic logic [W-1:0] extreme(input int i);
        case (i)
            0: return 24'hFFFFFF;
            1: return 24'h800000;
            2: return 24'h7FFFFF;
            3: return 24'h000001;
            4: return 24'hFFFFFF;
            5: return 24'h000000;
            6: return 24'h800001;
            default: return 24'hFFFFFE;
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what, input int n,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %b expected %b", tag, what, n, act, exp);
        end
    endtask

    initial begin
        int next_s = 4;
        int sidx   = 0;
        int rst_at = -1;
        int sp;
        logic [W-1:0] w;
        logic [W-1:0] y;
        string tag;
        for (int k = 0; k < NEXP; k++) begin
            exp_ser[k] = 1'b0;
            exp_fs[k]  = 1'b0;
            exp_tag[k] = "R5";
        end
        exp_tag[0] = "R1";
        exp_tag[1] = "R1";
        for (int k = 0; k < 4; k++) hist[k] = '0;

        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            check_bit(exp_tag[n], "ser_out", n, ser_out, exp_ser[n]);
            check_bit(exp_fs[n] ? "R4" : (n < 2 ? "R1" : "R4,R5"), "frm_sync", n,
                      frm_sync, exp_fs[n]);

            // drive for the coming edge; word_in noise exercises R10
            rst      = (n == 0);
            cap_stb  = 1'b0;
            cap_word = W'($urandom);
            if (n == rst_at) begin
                rst = 1'b1;
                for (int k = n + 1; k < n + 30; k++) begin
                    exp_ser[k] = 1'b0;
                    exp_fs[k]  = 1'b0;
                    exp_tag[k] = "R11";
                end
                for (int k = 0; k < 4; k++) hist[k] = '0;
            end else if (n == next_s && sidx < 46) begin
                if (sidx >= 30 && sidx < 38) w = extreme(sidx - 30);
                else                         w = W'($urandom);
                cap_stb  = 1'b1;
                cap_word = w;
                y = model_word(w);
                if (sidx == 0)       tag = "R1,R6";
                else if (sidx < 20)  tag = "R2,R3,R6,R8,R10";
                else if (sidx < 30)  tag = "R9";
                else if (sidx < 38)  tag = "R7";
                else if (sidx == 38) tag = "R11";
                else                 tag = "R6";
                for (int j = 0; j < W; j++) begin
                    exp_ser[n + 2 + j] = y[j];
                    exp_fs[n + 2 + j]  = (j == 0);
                    exp_tag[n + 2 + j] = tag;
                end
                if (sidx < 20)      sp = 32;
                else if (sidx < 30) sp = 24;
                else if (sidx < 38) sp = 40;
                else                sp = 32;
                if (sidx == 37) begin
                    rst_at = n + 12;
                    next_s = n + 17;
                end else begin
                    next_s = n + sp;
                end
                sidx++;
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule